// File: doc/BRIEF.md
# CPU Status and Stack-Pointer Unit

This block holds the architectural state of a small 8-bit processor core. It keeps an eight-flag status byte and a downward-growing stack pointer. Per-instruction control strobes and flag results from an external ALU update the flags. The strobes cover interrupt enable and disable, interrupt entry and return, bit transfer to and from the T flag, push and pop, and I/O-mapped reads and writes.

Instruction decode drives the strobes for one cycle each. The data memory takes the stack address from `stk_addr`. The interrupt controller gates every source with `gie`. All outputs come from registers.

Top module: `cpu_state_unit`

## Requirements
- R1: After a synchronous reset, the status byte is 0x00 and `gie` is 0. The stack pointer equals `TOP_RAM` truncated to `SP_W` bits, which is 0x01FF by default.
- R2: Interrupt entry (`int_take`) forces I (bit 7) to 0. It wins over `int_set` and `int_ret` in the same cycle.
- R3: `int_ret` and `int_set` set I, and `int_clr` clears it. `gie` always equals the stored I bit, so it is low whenever I is 0.
- R4: S (bit 4) always equals N (bit 2) xor V (bit 3), and it is recomputed whenever either changes. A value written to S directly is ignored.
- R5: Where `alu_mask` has a 1 at H (bit 5), V (bit 3), N (bit 2), Z (bit 1) or C (bit 0), that flag takes the matching bit of `alu_val`. Mask bits 7, 6 and 4 have no effect.
- R6: `bst_en` copies bit `bit_sel` of `reg_opnd` into T (bit 6).
- R7: `bld_en` makes `bld_result` equal `reg_opnd` with bit `bit_sel` replaced by the current T. The result appears one cycle later and is held until the next load.
- R8: In a push cycle `stk_addr` shows the current pointer, which is the write address. The pointer then decrements by one, wrapping within `SP_W` bits.
- R9: A pop increments the pointer. The incremented address appears on `stk_addr` in the next cycle for the read. Push and pop never occur in the same cycle.
- R10: Only `SP_W` pointer bits (default 10) are stored. Higher bits read as 0 and ignore writes.
- R11: The I/O read data is registered and reflects the state before the clock edge. Address `A_SPLO` (0x20) returns the low pointer byte, `A_SPHI` (0x21) the high byte, `A_STAT` (0x22) the status byte, and any other address returns 0.
- R12: An I/O write to the status byte or to a pointer byte takes priority over flag strobes or push/pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_set | input | 1 | Enable interrupts strobe |
| int_clr | input | 1 | Disable interrupts strobe |
| int_take | input | 1 | Interrupt entry strobe |
| int_ret | input | 1 | Return-from-interrupt strobe |
| alu_mask | input | 8 | Which flags the ALU updates |
| alu_val | input | 8 | ALU flag values |
| bst_en | input | 1 | Bit store into T |
| bld_en | input | 1 | Bit load from T |
| bit_sel | input | 3 | Bit index for store/load |
| reg_opnd | input | 8 | Register operand |
| push_en | input | 1 | Stack push |
| pop_en | input | 1 | Stack pop |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | AW | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| flags | output | 8 | Status byte |
| gie | output | 1 | Global interrupt enable |
| stk_addr | output | 16 | Stack address (zero-extended pointer) |
| bld_result | output | 8 | Bit-load result byte |

## Verification
The flags are driven with an all-ones ALU mask and with a single-flag mask. This separates masked from unmasked updates and shows S following N xor V. Conflicting strobes are issued in one cycle (entry with enable, I/O write with entry, I/O write with push) to check priority. The pointer is pushed and popped near its default top and at zero, which tests wrap within `SP_W` bits. High-byte writes with all ones show which bits are stored. Bit store and load use set and clear T values at edge bit positions.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;
endpackage

// File: rtl/status_flags.sv
module status_flags
  import cpu_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       int_set,
  input  logic       int_clr,
  input  logic       int_take,
  input  logic       int_ret,
  input  logic [7:0] alu_mask,
  input  logic [7:0] alu_val,
  input  logic       t_load,
  input  logic       t_val,
  input  logic       io_we,
  input  logic [7:0] io_wdata,
  output logic [7:0] stat
);
  logic [7:0] nxt;

  always_comb begin
    nxt = stat;
    if (io_we) begin
      nxt = io_wdata;
    end else begin
      if (int_take)                nxt[FLG_I] = 1'b0;
      else if (int_clr)            nxt[FLG_I] = 1'b0;
      else if (int_set || int_ret) nxt[FLG_I] = 1'b1;
      if (t_load) nxt[FLG_T] = t_val;
      for (int i = 0; i < 8; i++) begin
        if (i != FLG_I && i != FLG_T && i != FLG_S && alu_mask[i])
          nxt[i] = alu_val[i];
      end
    end
    nxt[FLG_S] = nxt[FLG_N] ^ nxt[FLG_V];
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= nxt;
  end

  AST_TAKE_CLEARS_I: assert property (@(posedge clk) disable iff (rst)
    (int_take && !io_we) |=> !stat[FLG_I]); // R2
  AST_RET_SETS_I: assert property (@(posedge clk) disable iff (rst)
    (int_ret && !int_take && !int_clr && !io_we) |=> stat[FLG_I]); // R3
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    stat[FLG_S] == (stat[FLG_N] ^ stat[FLG_V])); // R4
  AST_IO_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    io_we |=> (stat[7:5] == $past(io_wdata[7:5]) && stat[3:0] == $past(io_wdata[3:0]))); // R12
endmodule

// File: rtl/stack_pointer.sv
module stack_pointer #(
  parameter int          SP_W    = 10,
  parameter logic [15:0] TOP_RAM = 16'h01FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_en,
  input  logic            pop_en,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic [7:0]      wdata,
  output logic [SP_W-1:0] sp
);
  localparam int HI_W = SP_W - 8;
  localparam logic [SP_W-1:0] SP_RST = TOP_RAM[SP_W-1:0];
  localparam logic [SP_W-1:0] ONE    = {{(SP_W-1){1'b0}}, 1'b1};

  logic [SP_W-1:0] nxt;

  always_comb begin
    nxt = sp;
    if (we_lo || we_hi) begin
      if (we_lo) nxt[7:0]      = wdata;
      if (we_hi) nxt[SP_W-1:8] = wdata[HI_W-1:0];
    end else if (push_en) begin
      nxt = sp - ONE;
    end else if (pop_en) begin
      nxt = sp + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= SP_RST;
    else     sp <= nxt;
  end

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(push_en && pop_en)); // R9
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
    (push_en && !we_lo && !we_hi) |=> sp == $past(sp) - ONE); // R8
  AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !we_lo && !we_hi) |=> sp == $past(sp) + ONE); // R9
endmodule

// File: rtl/bit_xfer.sv
module bit_xfer (
  input  logic       clk,
  input  logic       rst,
  input  logic       bld_en,
  input  logic [2:0] bit_sel,
  input  logic [7:0] opnd,
  input  logic       t_cur,
  output logic       t_pick,
  output logic [7:0] bld_result
);
  assign t_pick = opnd[bit_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      bld_result <= '0;
    end else if (bld_en) begin
      bld_result          <= opnd;
      bld_result[bit_sel] <= t_cur;
    end
  end

  AST_BLD_BIT: assert property (@(posedge clk) disable iff (rst)
    bld_en |=> bld_result[$past(bit_sel)] == $past(t_cur)); // R7
  AST_BLD_OTHERS: assert property (@(posedge clk) disable iff (rst)
    bld_en |=> $countones(bld_result ^ $past(opnd)) <= 1); // R7
endmodule

// File: rtl/cpu_state_unit.sv
module cpu_state_unit
  import cpu_state_pkg::*;
#(
  parameter int          SP_W    = 10,
  parameter logic [15:0] TOP_RAM = 16'h01FF,
  parameter int          AW      = 6,
  parameter logic [AW-1:0] A_SPLO = 6'h20,
  parameter logic [AW-1:0] A_SPHI = 6'h21,
  parameter logic [AW-1:0] A_STAT = 6'h22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          int_set,
  input  logic          int_clr,
  input  logic          int_take,
  input  logic          int_ret,
  input  logic [7:0]    alu_mask,
  input  logic [7:0]    alu_val,
  input  logic          bst_en,
  input  logic          bld_en,
  input  logic [2:0]    bit_sel,
  input  logic [7:0]    reg_opnd,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          io_we,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic [7:0]    flags,
  output logic          gie,
  output logic [15:0]   stk_addr,
  output logic [7:0]    bld_result
);
  localparam int PAD = 16 - SP_W;

  logic [7:0]      stat;
  logic [SP_W-1:0] sp;
  logic            t_pick;
  logic            we_stat, we_lo, we_hi;

  assign we_stat = io_we && (io_addr == A_STAT);
  assign we_lo   = io_we && (io_addr == A_SPLO);
  assign we_hi   = io_we && (io_addr == A_SPHI);

  status_flags u_flags (
    .clk(clk), .rst(rst),
    .int_set(int_set), .int_clr(int_clr), .int_take(int_take), .int_ret(int_ret),
    .alu_mask(alu_mask), .alu_val(alu_val),
    .t_load(bst_en), .t_val(t_pick),
    .io_we(we_stat), .io_wdata(io_wdata),
    .stat(stat)
  );

  stack_pointer #(.SP_W(SP_W), .TOP_RAM(TOP_RAM)) u_sp (
    .clk(clk), .rst(rst),
    .push_en(push_en), .pop_en(pop_en),
    .we_lo(we_lo), .we_hi(we_hi), .wdata(io_wdata),
    .sp(sp)
  );

  bit_xfer u_bits (
    .clk(clk), .rst(rst),
    .bld_en(bld_en), .bit_sel(bit_sel), .opnd(reg_opnd),
    .t_cur(stat[FLG_T]), .t_pick(t_pick), .bld_result(bld_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else begin
      case (io_addr)
        A_SPLO:  io_rdata <= sp[7:0];
        A_SPHI:  io_rdata <= {{PAD{1'b0}}, sp[SP_W-1:8]};
        A_STAT:  io_rdata <= stat;
        default: io_rdata <= '0;
      endcase
    end
  end

  assign flags    = stat;
  assign gie      = stat[FLG_I];
  assign stk_addr = {{PAD{1'b0}}, sp};

  AST_GIE_LOW: assert property (@(posedge clk) disable iff (rst)
    (int_take && !we_stat) |=> !gie); // R3
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    stk_addr[15:SP_W] == '0); // R10
endmodule

// File: tb/tb_cpu_state_unit.sv
module tb_cpu_state_unit;
  logic       clk = 0;
  logic       rst = 1;
  logic       int_set = 0, int_clr = 0, int_take = 0, int_ret = 0;
  logic [7:0] alu_mask = 0, alu_val = 0;
  logic       bst_en = 0, bld_en = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] reg_opnd = 0;
  logic       push_en = 0, pop_en = 0, io_we = 0;
  logic [5:0] io_addr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata, flags, bld_result;
  logic       gie;
  logic [15:0] stk_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int kind; int val; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  cpu_state_unit dut (
    .clk(clk), .rst(rst), .int_set(int_set), .int_clr(int_clr),
    .int_take(int_take), .int_ret(int_ret), .alu_mask(alu_mask), .alu_val(alu_val),
    .bst_en(bst_en), .bld_en(bld_en), .bit_sel(bit_sel), .reg_opnd(reg_opnd),
    .push_en(push_en), .pop_en(pop_en), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .flags(flags), .gie(gie),
    .stk_addr(stk_addr), .bld_result(bld_result)
  );

  // kinds: 0 flags, 1 stk_addr, 2 gie, 3 bld_result, 4 io_rdata
  task automatic expect_item(int kind, int val, string req);
    item_t it;
    it.kind = kind; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(flags);
        1: act = int'(stk_addr);
        2: act = int'(gie);
        3: act = int'(bld_result);
        default: act = int'(io_rdata);
      endcase
      checks++;
      if (act != it.val) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    int_set = 0; int_clr = 0; int_take = 0; int_ret = 0;
    alu_mask = 0; bst_en = 0; bld_en = 0; push_en = 0; pop_en = 0; io_we = 0;
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    expect_item(0, 8'h00, "R1"); expect_item(1, 16'h01FF, "R1"); expect_item(2, 0, "R1");
    io_addr = 6'h21; cyc(); expect_item(4, 8'h01, "R11");
    io_addr = 6'h00;
    int_set = 1; cyc(); expect_item(0, 8'h80, "R3"); expect_item(2, 1, "R3");
    int_take = 1; int_set = 1; cyc(); expect_item(0, 8'h00, "R2"); expect_item(2, 0, "R2");
    int_ret = 1; cyc(); expect_item(0, 8'h80, "R3");
    int_clr = 1; cyc(); expect_item(2, 0, "R3");
    alu_mask = 8'hFF; alu_val = 8'hFF; cyc(); expect_item(0, 8'h2F, "R5");
    alu_mask = 8'h08; alu_val = 8'h00; cyc(); expect_item(0, 8'h37, "R4");
    io_addr = 6'h22; io_we = 1; io_wdata = 8'h10; cyc(); expect_item(0, 8'h00, "R4");
    io_we = 1; io_wdata = 8'hC4; int_take = 1; alu_mask = 8'hFF; alu_val = 8'h00;
    cyc(); expect_item(0, 8'hD4, "R12");
    io_addr = 6'h00;
    bst_en = 1; reg_opnd = 8'h00; bit_sel = 3; cyc(); expect_item(0, 8'h94, "R6");
    bst_en = 1; reg_opnd = 8'h08; bit_sel = 3; cyc(); expect_item(0, 8'hD4, "R6");
    bld_en = 1; reg_opnd = 8'h00; bit_sel = 5; cyc(); expect_item(3, 8'h20, "R7");
    bst_en = 1; reg_opnd = 8'h00; bit_sel = 0; cyc(); expect_item(3, 8'h20, "R7");
    bld_en = 1; reg_opnd = 8'hFF; bit_sel = 7; cyc(); expect_item(3, 8'h7F, "R7");
    io_addr = 6'h22; cyc(); expect_item(4, 8'h94, "R11");
    io_addr = 6'h00;
    push_en = 1; #3 expect_item(1, 16'h01FF, "R8"); cyc(); expect_item(1, 16'h01FE, "R8");
    push_en = 1; cyc(); expect_item(1, 16'h01FD, "R8");
    pop_en = 1; cyc(); expect_item(1, 16'h01FE, "R9");
    io_addr = 6'h21; io_we = 1; io_wdata = 8'hFF; cyc(); expect_item(1, 16'h03FE, "R10");
    cyc(); expect_item(4, 8'h03, "R10");
    io_addr = 6'h20; cyc(); expect_item(4, 8'hFE, "R11");
    io_we = 1; io_wdata = 8'h00; cyc();
    io_addr = 6'h21; io_we = 1; io_wdata = 8'h00; cyc(); expect_item(1, 16'h0000, "R10");
    io_addr = 6'h00;
    push_en = 1; cyc(); expect_item(1, 16'h03FF, "R10");
    pop_en = 1; cyc(); expect_item(1, 16'h0000, "R9");
    io_addr = 6'h20; io_we = 1; io_wdata = 8'h55; push_en = 1; cyc(); expect_item(1, 16'h0055, "R12");
    io_addr = 6'h00; cyc(); expect_item(4, 8'h00, "R11");
    cyc(); cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule